// File: doc/BRIEF.md
# Multichannel ADC Acquisition Sequencer

This block sequences conversions for a 16-channel ADC front end and stores the results in a 1024-word sample FIFO. Software programs it through a small byte-wide register file. The registers set the conversion trigger source, a pretrigger flag, automatic channel scanning, the channel or scan limit, a gain code, the interrupt event selection and the FIFO enable. Samples are read back through a 16-bit data port.

A conversion can start in three ways: a write to the software-trigger register, a pulse on the pacer tick input, or a pulse on the external trigger input. Only the selected source starts a conversion. The ADC is modelled as a request/done handshake. The block raises a request and holds the channel and gain code steady until the converter reports done with its 16-bit result. The result is then pushed into the FIFO. With autoscan on, the conversions step through channels 0 up to the programmed limit and then wrap back to 0.

Two sticky interrupt lines report selected events. Each line stays high until software writes the interrupt-clear register.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, all configuration registers read 0. The status byte reads 0x60. Both interrupt lines are low and no conversion is requested.
- R2: The trigger-mode register (address 3) keeps write bits 3:0: bit 3 pretrigger, bit 2 external select, bit 1 pacer select, bit 0 autoscan. A read returns these four bits, with bits 7:4 reading zero.
- R3: Only the selected source starts a conversion. Bit 2 set selects the external pulse. Bit 2 clear and bit 1 set selects the pacer tick. Both clear selects any write to address 5. A trigger that arrives while a conversion is in progress is ignored.
- R4: The request `adc_req` rises on the clock edge that accepts a trigger. It stays high, with `adc_chan` and `adc_range` stable, until the clock edge on which `adc_done` is high. Status bit 7 reads 1 (busy) while the request is pending.
- R5: With autoscan on, successive conversions use channels 0, 1, … up to the limit in the channel register (address 1), then wrap back to 0. A write to the channel register restarts the scan at 0. With autoscan off, every conversion uses the register value. A read of address 1 returns the current channel in bits 3:0.
- R6: Each completed conversion pushes `adc_data` into the FIFO. A read of address 0 pops the samples in the order they were converted.
- R7: The status byte (read at address 2) holds the range code in bits 2:0 and bit 3 reads 0. It carries three active-low flags: bit 4 is 0 when the FIFO is empty, bit 5 is 0 when it holds 512 or more samples, and bit 6 is 0 when it holds 1024 samples.
- R8: When the FIFO holds 1024 samples, further results are dropped and the full flag stays asserted until a read or a FIFO reset.
- R9: A read of address 0 on an empty FIFO returns the most recently popped word and leaves the FIFO unchanged.
- R10: Interrupt-control (address 4) bit 2 set clears the FIFO and blocks pushes. The write sequence enable, disable, enable therefore empties the FIFO.
- R11: Interrupt-control bit 0 selects the event that sets `irq0`. With bit 0 clear, every completed conversion sets it. With bit 0 set, the push that brings the FIFO to 512 samples sets it.
- R12: Interrupt-control bit 1 selects the event that sets `irq1`. With bit 1 clear, a pacer tick sets it. With bit 1 set, an external trigger pulse sets it.
- R13: Both interrupt lines are sticky. Any write to address 6 clears them. A set event in the same cycle as the clear write takes priority.
- R14: The 3-bit range register (address 2 write) is captured at the start of every conversion and driven on `adc_range`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the FIFO at address 0) |
| reg_addr | input | 3 | Register address |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 16 | Combinational read data for `reg_addr` |
| pacer_tick | input | 1 | One-cycle pacer pulse |
| ext_trig | input | 1 | One-cycle external trigger pulse |
| adc_req | output | 1 | Conversion request |
| adc_chan | output | 4 | Channel for the current conversion |
| adc_range | output | 3 | Gain code for the current conversion |
| adc_done | input | 1 | Conversion complete |
| adc_data | input | 16 | Conversion result |
| irq0 | output | 1 | Interrupt line 0 (conversion end or half full) |
| irq1 | output | 1 | Interrupt line 1 (pacer tick or external trigger) |

## Verification
The assertions assume that `adc_done` is asserted only while a request is pending. They also assume that the trigger inputs are single-cycle pulses sampled on the clock, and that the channel register is not rewritten during a conversion. The stimulus meets these assumptions by construction. The bench raises `adc_done` only after it has seen `adc_req` high, drives each pulse for exactly one clock, and changes the channel register only between conversions. Random stimulus mixes conversions, data reads and channel changes around directed cases for the trigger sources, fill to full, empty reads and interrupt clear collisions.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int DEPTH = 1024,
  parameter int DW    = 16,
  parameter int CHW   = 4,
  parameter int RGW   = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [2:0]     reg_addr,
  input  logic [7:0]     wr_data,
  output logic [DW-1:0]  rd_data,
  input  logic           pacer_tick,
  input  logic           ext_trig,
  output logic           adc_req,
  output logic [CHW-1:0] adc_chan,
  output logic [RGW-1:0] adc_range,
  input  logic           adc_done,
  input  logic [DW-1:0]  adc_data,
  output logic           irq0,
  output logic           irq1
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = AW + 1;
  localparam int HALF = DEPTH / 2;

  localparam logic [2:0] A_DATA = 3'd0, A_CHAN = 3'd1, A_RANGE = 3'd2,
                         A_TRIG = 3'd3, A_ICTL = 3'd4, A_SWTRG = 3'd5,
                         A_ICLR = 3'd6;

  logic [3:0]     trig_q;
  logic [2:0]     ictl_q;
  logic [CHW-1:0] chan_q, scan_q, conv_chan_q;
  logic [RGW-1:0] rng_q, conv_rng_q;
  logic           busy_q, irq0_q, irq1_q;
  logic [DW-1:0]  mem [DEPTH];
  logic [AW-1:0]  wp_q, rp_q;
  logic [CW-1:0]  cnt_q;
  logic [DW-1:0]  last_q;

  logic unused_ok;
  assign unused_ok = ^wr_data[7:4];

  wire wr_chan  = reg_wr && reg_addr == A_CHAN;
  wire wr_range = reg_wr && reg_addr == A_RANGE;
  wire wr_trig  = reg_wr && reg_addr == A_TRIG;
  wire wr_ictl  = reg_wr && reg_addr == A_ICTL;
  wire wr_sw    = reg_wr && reg_addr == A_SWTRG;
  wire wr_clr   = reg_wr && reg_addr == A_ICLR;

  wire fifo_on  = ~ictl_q[2];
  wire autoscan = trig_q[0];
  wire trig_hit = trig_q[2] ? ext_trig : (trig_q[1] ? pacer_tick : wr_sw);
  wire start    = trig_hit && !busy_q;
  wire done     = busy_q && adc_done;

  wire empty = cnt_q == '0;
  wire full  = cnt_q == CW'(DEPTH);
  wire half  = cnt_q >= CW'(HALF);
  wire push  = done && fifo_on && !full;
  wire pop   = reg_rd && reg_addr == A_DATA && !empty;

  wire [CHW-1:0] cur_chan = autoscan ? scan_q : chan_q;
  wire half_evt = push && !pop && cnt_q == CW'(HALF - 1);
  wire set0 = ictl_q[0] ? half_evt : done;
  wire set1 = ictl_q[1] ? ext_trig : pacer_tick;
  wire [7:0] status = {busy_q, ~full, ~half, ~empty, 4'(rng_q)};

  assign adc_req   = busy_q;
  assign adc_chan  = conv_chan_q;
  assign adc_range = conv_rng_q;
  assign irq0      = irq0_q;
  assign irq1      = irq1_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_q <= '0;
      ictl_q <= '0;
      chan_q <= '0;
      rng_q  <= '0;
    end else begin
      if (wr_trig)  trig_q <= wr_data[3:0];
      if (wr_ictl)  ictl_q <= wr_data[2:0];
      if (wr_chan)  chan_q <= wr_data[CHW-1:0];
      if (wr_range) rng_q  <= wr_data[RGW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      scan_q      <= '0;
      conv_chan_q <= '0;
      conv_rng_q  <= '0;
    end else begin
      if (start) begin
        busy_q      <= 1'b1;
        conv_chan_q <= cur_chan;
        conv_rng_q  <= rng_q;
      end else if (done) begin
        busy_q <= 1'b0;
      end
      if (wr_chan)
        scan_q <= '0;
      else if (done && autoscan)
        scan_q <= (scan_q >= chan_q) ? '0 : scan_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= adc_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q   <= '0;
      rp_q   <= '0;
      cnt_q  <= '0;
      last_q <= '0;
    end else begin
      if (pop) last_q <= mem[rp_q];
      if (!fifo_on) begin
        wp_q  <= '0;
        rp_q  <= '0;
        cnt_q <= '0;
      end else begin
        if (push) wp_q <= wp_q + 1'b1;
        if (pop)  rp_q <= rp_q + 1'b1;
        cnt_q <= cnt_q + CW'(push) - CW'(pop);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq0_q <= 1'b0;
      irq1_q <= 1'b0;
    end else begin
      irq0_q <= set0 | (irq0_q & ~wr_clr);
      irq1_q <= set1 | (irq1_q & ~wr_clr);
    end
  end

  always_comb begin
    rd_data = '0;
    case (reg_addr)
      A_DATA:  rd_data = empty ? last_q : mem[rp_q];
      A_CHAN:  rd_data = DW'(cur_chan);
      A_RANGE: rd_data = DW'(status);
      A_TRIG:  rd_data = DW'(trig_q);
      A_ICTL:  rd_data = DW'(ictl_q);
      default: rd_data = '0;
    endcase
  end

  assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    adc_req && !adc_done |=> adc_req && $stable(adc_chan) && $stable(adc_range));

  assert_full_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    full && !pop && fifo_on && !wr_ictl |=> full);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  assert_fifo_off_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ictl_q[2] |=> empty);

  assert_irq_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (irq0 && !wr_clr) |=> irq0);
endmodule

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] wr_data = 0;
  logic [15:0] rd_data;
  logic pacer_tick = 0, ext_trig = 0, adc_done = 0;
  logic [15:0] adc_data = 0;
  logic adc_req, irq0, irq1;
  logic [3:0] adc_chan;
  logic [2:0] adc_range;

  int checks = 0, fails = 0;
  logic [15:0] q[$];
  logic [15:0] last_w = 0;
  bit fifo_en = 1;

  always #4 clk = ~clk;

  adc_seq_ctrl i_adc_seq_ctrl (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status(int n, logic busy, logic [2:0] r);
    return {busy, n != 1024, n < 512, n != 0, 1'b0, r};
  endfunction

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; wr_data = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] v);
    @(negedge clk); reg_addr = a; reg_rd = (a == 0);
    #1 v = rd_data;
    if (a == 0) begin
      if (q.size() > 0) last_w = q.pop_front();
    end
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic respond(logic [15:0] d);
    adc_done = 1; adc_data = d;
    @(negedge clk); adc_done = 0;
    if (fifo_en && q.size() < 1024) q.push_back(d);
  endtask

  task automatic sw_conv(logic [15:0] d, output logic [3:0] ch, output logic [2:0] rg);
    wr(5, 8'h00);
    chk("R4 req after trigger", adc_req, 1);
    ch = adc_chan; rg = adc_range;
    respond(d);
  endtask

  task automatic pulse(bit is_ext);
    @(negedge clk); if (is_ext) ext_trig = 1; else pacer_tick = 1;
    @(negedge clk); ext_trig = 0; pacer_tick = 0;
  endtask

  task automatic pop_chk(string req);
    logic [15:0] v, e;
    e = (q.size() > 0) ? q[0] : last_w;
    rd(0, v);
    chk(req, v, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [3:0] ch;
    logic [2:0] rg;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst_n = 1;

    rd(2, v); chk("R1 status", v, 16'h0060);
    rd(3, v); chk("R1 trig", v, 0);
    rd(4, v); chk("R1 ictl", v, 0);
    chk("R1 irq", {irq0, irq1, adc_req}, 0);

    wr(3, 8'h0A); rd(3, v); chk("R2 readback", v, 16'h000A);
    wr(3, 8'hF5); rd(3, v); chk("R2 upper ignored", v, 16'h0005);
    wr(3, 8'h00);

    wr(5, 0);
    chk("R3 sw start", adc_req, 1);
    rd(2, v); chk("R4 busy bit", v[7], 1);
    chk("R4 chan", adc_chan, 0);
    respond(16'h1234);
    pop_chk("R6 data");
    pulse(0); chk("R3 tick ignored in sw mode", adc_req, 0);
    wr(3, 8'h02);
    wr(5, 0); chk("R3 sw ignored in pacer mode", adc_req, 0);
    pulse(1); chk("R3 ext ignored in pacer mode", adc_req, 0);
    pulse(0); chk("R3 pacer start", adc_req, 1);
    respond(16'hBEEF);
    wr(3, 8'h04);
    pulse(0); chk("R3 tick ignored in ext mode", adc_req, 0);
    pulse(1); chk("R3 ext start", adc_req, 1);
    respond(16'h0F0F);
    pop_chk("R6 order 1"); pop_chk("R6 order 2");
    wr(3, 8'h00);
    wr(5, 0); wr(5, 0);
    respond(16'h5555);
    pop_chk("R3 busy trigger dropped");
    rd(2, v); chk("R3 single entry", v[4], 0);

    wr(2, 8'h05);
    sw_conv(16'h0A0A, ch, rg);
    chk("R14 range", rg, 5);
    rd(2, v); chk("R7 range bits", v[7:0], exp_status(1, 0, 5));
    pop_chk("R6 range sample");
    wr(2, 8'h00);

    wr(1, 8'h02); wr(3, 8'h01);
    for (int i = 0; i < 4; i++) begin
      sw_conv(16'(i), ch, rg);
      chk("R5 autoscan chan", ch, (i == 3) ? 0 : i);
    end
    rd(1, v); chk("R5 readback scan", v, 1);
    wr(3, 8'h00); wr(1, 8'h09);
    sw_conv(16'h7777, ch, rg);
    chk("R5 fixed chan", ch, 9);
    rd(1, v); chk("R5 readback fixed", v, 9);
    while (q.size() > 0) pop_chk("R6 drain");

    wr(6, 0);
    chk("R13 cleared", {irq0, irq1}, 0);
    sw_conv(16'h1111, ch, rg);
    chk("R11 eoc irq", irq0, 1);
    wr(6, 0); chk("R13 clear irq0", irq0, 0);
    pulse(0); chk("R12 tick irq1", irq1, 1);
    wr(6, 0); chk("R13 clear irq1", irq1, 0);
    wr(4, 8'h02);
    pulse(0); chk("R12 tick masked", irq1, 0);
    pulse(1); chk("R12 ext irq1", irq1, 1);
    @(negedge clk); reg_wr = 1; reg_addr = 6; ext_trig = 1;
    @(negedge clk); reg_wr = 0; ext_trig = 0;
    chk("R13 set wins", irq1, 1);
    wr(6, 0);
    wr(4, 8'h00);

    for (int i = 0; i < 300; i++) begin
      int r;
      r = $urandom % 5;
      if (r < 2) begin
        logic [3:0] c;
        c = 4'($urandom);
        wr(1, {4'h0, c});
        sw_conv(16'($urandom), ch, rg);
        chk("R5 random chan", ch, c);
      end else if (r < 4) begin
        pop_chk("R6 random read");
      end else begin
        rd(2, v);
        chk("R7 random status", v[7:0], exp_status(q.size(), 0, 0));
      end
    end
    while (q.size() > 0) pop_chk("R6 drain");
    pop_chk("R9 empty read 1");
    pop_chk("R9 empty read 2");
    rd(2, v); chk("R9 still empty", v[4], 0);

    sw_conv(16'h0101, ch, rg); sw_conv(16'h0202, ch, rg);
    wr(4, 8'h00); wr(4, 8'h04); fifo_en = 0; q.delete();
    sw_conv(16'h0303, ch, rg);
    wr(4, 8'h01); fifo_en = 1;
    rd(2, v); chk("R10 reset empties", v[7:0], exp_status(0, 0, 0));
    pop_chk("R10 last word kept");

    wr(6, 0);
    for (int i = 0; i < 511; i++) sw_conv(16'(i) ^ 16'hA5C3, ch, rg);
    chk("R11 below half", irq0, 0);
    rd(2, v); chk("R7 511 status", v[7:0], exp_status(511, 0, 0));
    sw_conv(16'(511) ^ 16'hA5C3, ch, rg);
    chk("R11 half irq", irq0, 1);
    rd(2, v); chk("R7 half status", v[7:0], exp_status(512, 0, 0));
    for (int i = 512; i < 1026; i++) sw_conv(16'(i) ^ 16'hA5C3, ch, rg);
    rd(2, v); chk("R8 full status", v[7:0], exp_status(1024, 0, 0));
    for (int i = 0; i < 1024; i++) begin
      rd(0, v);
      chk("R8 fill order", v, 16'(i) ^ 16'hA5C3);
      if (q.size() > 0) void'(q.pop_front());
    end
    last_w = 16'(1023) ^ 16'hA5C3;
    pop_chk("R9 empty after full");
    rd(2, v); chk("R7 empty status", v[7:0], exp_status(0, 0, 0));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule